// File: doc/BRIEF.md
# Debug Link Control Command Handler

This block sits behind the receiver of a half-duplex single-wire debug link and carries out a small set of control commands. Each request arrives as two bytes over a byte-valid handshake: a command byte, then one data byte. The command can hold the CPU, assert or release a set of reset domains, or change the turnaround delay of the link. Every request is answered with a single response byte: 0x40 for acknowledge, 0x41 for refusal.

The link is half-duplex, so the master needs time to release the wire before the slave drives it. The handler therefore holds each response back for a guard interval after the data byte. The interval is counted in bit periods taken from a one-cycle bit tick input, and it is selected by a two-bit code. The number of reset domains is a parameter.

Top module: `dbg_cmd_handler`

## Requirements
- R1: After reset, `cpu_halt` is 0, every bit of `dom_rst` is 0, `rx_ready` is 1, `tx_valid` is 0, and the guard code is 0, which means a delay of 128 bit ticks.
- R2: Command 0x82 with data 0x01 sets `cpu_halt`, and with data 0x00 clears it. Both are answered with 0x40.
- R3: Command 0x82 with any other data byte leaves `cpu_halt` as it was and is answered with 0x41.
- R4: Command 0x83 copies data bits [NUM_DOM-1:0] to `dom_rst`, where 1 means the domain is held in reset. It ignores the higher data bits and is answered with 0x40.
- R5: Command 0x84 whose data byte has bits [7:2] clear stores bits [1:0] as the guard code and is answered with 0x40. The codes 0, 1, 2 and 3 select 128, 16, 4 and 1 bit ticks. The new code applies from the next command on; the response to the 0x84 itself still uses the previous delay.
- R6: Command 0x84 with any of data bits [7:2] set keeps the previous guard code and is answered with 0x41.
- R7: Any other command code still takes one data byte, changes no output and is answered with 0x41.
- R8: Counting starts on the cycle after the data byte is accepted. A tick present in the acceptance cycle is not counted. `tx_valid` rises the cycle after the clock edge that counts the last tick. Cycles without a tick do not advance the count.
- R9: Once `tx_valid` is high, it stays high and `tx_data` stays constant until a cycle with `tx_ready` high. From data acceptance until that cycle, `rx_ready` is 0 and bytes presented on the receive side are ignored.
- R10: `cpu_halt` and `dom_rst` change only in the cycle after a data byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte: a command code or a data byte |
| rx_ready | output | 1 | The handler accepts a byte this cycle |
| bit_tick | input | 1 | One-cycle pulse per bit period of the link |
| tx_valid | output | 1 | A response byte is waiting for the transmitter |
| tx_data | output | 8 | Response byte, 0x40 or 0x41 |
| tx_ready | input | 1 | The transmitter takes the response this cycle |
| cpu_halt | output | 1 | CPU halt request |
| dom_rst | output | NUM_DOM | Reset request for each domain, 1 = held in reset |

## Verification
The assertions assume that the receiver front end keeps the command and data bytes in order. They also assume that `bit_tick` is a one-cycle strobe that never needs to be counted twice. The bench honours both: it presents each byte only while `rx_ready` is high and it keeps its tick at one pulse per cycle. The one exception is on purpose. While a response is pending, the bench drives a full command onto the receive side to show that the handler ignores it. It also stops the tick for a while to show that the guard count stands still.

// File: rtl/dbg_cmd_pkg.sv
// Package for the debug command handler: command and response codes,
// sequencer states and the mapping from guard code to guard length.
// Assumes that command bytes and data bytes arrive strictly alternating.
package dbg_cmd_pkg;

    localparam logic [7:0] CMD_HALT  = 8'h82;
    localparam logic [7:0] CMD_RESET = 8'h83;
    localparam logic [7:0] CMD_GUARD = 8'h84;

    localparam logic [7:0] RSP_ACK   = 8'h40;
    localparam logic [7:0] RSP_NAK   = 8'h41;

    localparam int GUARD_MAX = 128;
    localparam int GUARD_W   = $clog2(GUARD_MAX + 1);

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_DATA  = 2'd1,
        ST_GUARD = 2'd2,
        ST_SEND  = 2'd3
    } seq_state_t;

    // Guard length in bit periods for a two-bit guard code
    function automatic logic [GUARD_W-1:0] guard_len(input logic [1:0] code);
        case (code)
            2'd0:    guard_len = GUARD_W'(128);
            2'd1:    guard_len = GUARD_W'(16);
            2'd2:    guard_len = GUARD_W'(4);
            default: guard_len = GUARD_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/dbg_cmd_exec.sv
// Command executor. When exec is high it decodes the command and data bytes
// and updates the halt, reset-domain and guard-code state. It also registers
// the response byte. Assumes exec is high for one cycle per request.
module dbg_cmd_exec
    import dbg_cmd_pkg::*;
#(
    parameter int NUM_DOM = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec,
    input  logic [7:0]         cmd,
    input  logic [7:0]         data,
    output logic               cpu_halt,
    output logic [NUM_DOM-1:0] dom_rst,
    output logic [1:0]         guard_code,
    output logic [7:0]         rsp
);

    // Carry out one command and record its response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_halt   <= 1'b0;
            dom_rst    <= '0;
            guard_code <= 2'd0;
            rsp        <= RSP_NAK;
        end else if (exec) begin
            case (cmd)
                CMD_HALT: begin
                    if (data == 8'h01) begin
                        cpu_halt <= 1'b1;
                        rsp      <= RSP_ACK;
                    end else if (data == 8'h00) begin
                        cpu_halt <= 1'b0;
                        rsp      <= RSP_ACK;
                    end else begin
                        rsp      <= RSP_NAK;
                    end
                end
                CMD_RESET: begin
                    dom_rst <= data[NUM_DOM-1:0];
                    rsp     <= RSP_ACK;
                end
                CMD_GUARD: begin
                    if (data[7:2] == 6'd0) begin
                        guard_code <= data[1:0];
                        rsp        <= RSP_ACK;
                    end else begin
                        rsp        <= RSP_NAK;
                    end
                end
                default: rsp <= RSP_NAK;
            endcase
        end
    end

    // R3
    // bad_halt_keep_chk
    bad_halt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cmd == CMD_HALT && data > 8'h01) |=> ($stable(cpu_halt) && rsp == RSP_NAK));

    // R6
    // bad_guard_keep_chk
    bad_guard_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cmd == CMD_GUARD && data[7:2] != 6'd0) |=> ($stable(guard_code) && rsp == RSP_NAK));

    // R7
    // unknown_cmd_chk
    unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cmd != CMD_HALT && cmd != CMD_RESET && cmd != CMD_GUARD)
        |=> ($stable(cpu_halt) && $stable(dom_rst) && $stable(guard_code) && rsp == RSP_NAK));

    // R10
    // idle_outputs_chk
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> ($stable(cpu_halt) && $stable(dom_rst) && $stable(guard_code)));

endmodule

// File: rtl/dbg_guard_timer.sv
// Guard timer. A load sets the count to len. Each following tick takes one off
// the count. done pulses in the cycle in which the last tick arrives. Assumes
// that a load only happens while the timer is idle.
module dbg_guard_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             tick,
    output logic             done
);

    logic [CNT_W-1:0] cnt;
    logic             busy;

    assign busy = (cnt != '0);
    assign done = busy && tick && (cnt == CNT_W'(1)) && !load;

    // Load the count, then step it down on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (busy && tick) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // R8
    // hold_without_tick_chk
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));

    // R8
    // load_idle_only_chk
    load_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

endmodule

// File: rtl/dbg_cmd_seq.sv
// Request sequencer. It takes a command byte, then a data byte, waits for the
// guard timer and then offers the response until the transmitter takes it.
// Assumes that rx_valid is sampled only together with rx_ready.
module dbg_cmd_seq
    import dbg_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       exec,
    output logic [7:0] cmd_q,
    input  logic       timer_done,
    input  logic       tx_ready,
    output logic       tx_valid
);

    seq_state_t state;
    logic       accept;

    assign rx_ready = (state == ST_CMD) || (state == ST_DATA);
    assign accept   = rx_valid && rx_ready;
    assign exec     = accept && (state == ST_DATA);
    assign tx_valid = (state == ST_SEND);

    // Step through command byte, data byte, guard wait and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD;
            cmd_q <= 8'h00;
        end else begin
            case (state)
                ST_CMD: if (accept) begin
                    cmd_q <= rx_data;
                    state <= ST_DATA;
                end
                ST_DATA:  if (accept)     state <= ST_GUARD;
                ST_GUARD: if (timer_done) state <= ST_SEND;
                default:  if (tx_ready)   state <= ST_CMD;
            endcase
        end
    end

    // R9
    // busy_blocks_rx_chk
    busy_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> !rx_ready);

endmodule

// File: rtl/dbg_cmd_handler.sv
// Top of the debug command handler. It connects the sequencer, the executor
// and the guard timer. Assumes a receiver that delivers whole bytes and a
// bit_tick strobe of one cycle per bit period.
module dbg_cmd_handler
    import dbg_cmd_pkg::*;
#(
    parameter int NUM_DOM = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               rx_ready,
    input  logic               bit_tick,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    input  logic               tx_ready,
    output logic               cpu_halt,
    output logic [NUM_DOM-1:0] dom_rst
);

    localparam int CNT_W = GUARD_W;

    logic       exec;
    logic [7:0] cmd_q;
    logic [1:0] guard_code;
    logic       timer_done;

    dbg_cmd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .exec       (exec),
        .cmd_q      (cmd_q),
        .timer_done (timer_done),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid)
    );

    dbg_cmd_exec #(.NUM_DOM(NUM_DOM)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec       (exec),
        .cmd        (cmd_q),
        .data       (rx_data),
        .cpu_halt   (cpu_halt),
        .dom_rst    (dom_rst),
        .guard_code (guard_code),
        .rsp        (tx_data)
    );

    dbg_guard_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (exec),
        .len   (guard_len(guard_code)),
        .tick  (bit_tick),
        .done  (timer_done)
    );

    // R9
    // rsp_hold_chk
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: tb/sim_dbg_cmd_handler.sv
module sim_dbg_cmd_handler;

    localparam int NDOM = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_data = 8'h00;
    logic            rx_ready;
    logic            bit_tick = 1'b1;
    logic            tx_valid;
    logic [7:0]      tx_data;
    logic            tx_ready = 1'b0;
    logic            cpu_halt;
    logic [NDOM-1:0] dom_rst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dbg_cmd_handler #(.NUM_DOM(NDOM)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .bit_tick(bit_tick), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .cpu_halt(cpu_halt),
        .dom_rst(dom_rst)
    );

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] data;
        logic [7:0] rsp;
        logic       halt;
        logic [7:0] dom;
        logic [7:0] delay;
    } vec_t;

    // Expected values come from R2-R8; the delay is the guard in force before each request
    localparam vec_t VEC [13] = '{
        '{8'h82, 8'h01, 8'h40, 1'b1, 8'h00, 8'd128},  // R2 halt on
        '{8'h82, 8'h07, 8'h41, 1'b1, 8'h00, 8'd128},  // R3 bad data
        '{8'h83, 8'hFF, 8'h40, 1'b1, 8'h1F, 8'd128},  // R4 upper bits dropped
        '{8'h84, 8'h03, 8'h40, 1'b1, 8'h1F, 8'd128},  // R5 old delay used
        '{8'h82, 8'h00, 8'h40, 1'b0, 8'h1F, 8'd1},    // R2 halt off
        '{8'h84, 8'h05, 8'h41, 1'b0, 8'h1F, 8'd1},    // R6 rejected
        '{8'h84, 8'h02, 8'h40, 1'b0, 8'h1F, 8'd1},    // R5
        '{8'h83, 8'h0A, 8'h40, 1'b0, 8'h0A, 8'd4},    // R4
        '{8'h55, 8'h01, 8'h41, 1'b0, 8'h0A, 8'd4},    // R7 unknown
        '{8'h84, 8'h01, 8'h40, 1'b0, 8'h0A, 8'd4},    // R5
        '{8'h83, 8'hE0, 8'h40, 1'b0, 8'h00, 8'd16},   // R4 only high bits set
        '{8'h84, 8'h00, 8'h40, 1'b0, 8'h00, 8'd16},   // R5
        '{8'h82, 8'h01, 8'h40, 1'b1, 8'h00, 8'd128}   // R2
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_req(input logic [7:0] c, input logic [7:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_data = c;
        @(posedge clk);
        @(negedge clk); rx_data = d;
        @(posedge clk);
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic wait_rsp(output int dly);
        dly = 0;
        while (!tx_valid && dly < 1000) begin
            @(posedge clk); @(negedge clk); dly++;
        end
    endtask

    task automatic take_rsp();
        tx_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int dly;
        logic [7:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(cpu_halt == 1'b0, "R1 halt", cpu_halt, 0);
        check(dom_rst == '0, "R1 dom", dom_rst, 0);
        check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);

        for (int i = 0; i < 13; i++) begin
            send_req(VEC[i].cmd, VEC[i].data);
            // R10 outputs already updated after acceptance
            check(cpu_halt == VEC[i].halt, "R10 halt", cpu_halt, VEC[i].halt);
            check(rx_ready == 1'b0, "R9 rx_ready busy", rx_ready, 0);
            wait_rsp(dly);
            check(dly == int'(VEC[i].delay), "R8 guard delay", dly, VEC[i].delay);
            check(tx_data == VEC[i].rsp, "R2-7 response", tx_data, VEC[i].rsp);
            check(cpu_halt == VEC[i].halt, "R2 R3 halt", cpu_halt, VEC[i].halt);
            check(dom_rst == VEC[i].dom[NDOM-1:0], "R4 R7 dom", dom_rst, VEC[i].dom[NDOM-1:0]);
            take_rsp();
            check(tx_valid == 1'b0, "R9 tx released", tx_valid, 0);
        end

        // R9: response held while the transmitter is busy, receive side ignored
        send_req(8'h83, 8'h03);
        wait_rsp(dly);
        held = tx_data;
        rx_valid = 1'b1; rx_data = 8'h82;
        @(posedge clk); @(negedge clk);
        rx_data = 8'h00;
        repeat (4) begin
            @(posedge clk); @(negedge clk);
            check(tx_valid == 1'b1 && tx_data == held, "R9 hold", tx_data, held);
            check(rx_ready == 1'b0, "R9 rx blocked", rx_ready, 0);
        end
        rx_valid = 1'b0;
        take_rsp();
        check(cpu_halt == 1'b1, "R9 ignored halt", cpu_halt, 1);
        check(dom_rst == 5'h03, "R4 dom", dom_rst, 3);

        // R8: no ticks, no progress; then full 128 tick delay
        bit_tick = 1'b0;
        send_req(8'h83, 8'h00);
        check(dom_rst == '0, "R10 dom update", dom_rst, 0);
        repeat (200) @(negedge clk);
        check(tx_valid == 1'b0, "R8 stalled", tx_valid, 0);
        bit_tick = 1'b1;
        wait_rsp(dly);
        check(dly == 128, "R8 resumed delay", dly, 128);
        check(tx_data == 8'h40, "R4 ack", tx_data, 8'h40);
        take_rsp();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule